// File: doc/BRIEF.md
# NaN Classifier and Quieter

This block looks at one floating-point word and sorts it into three classes: quiet NaN, signaling NaN, or not a NaN. The word can be in one of four formats, and a select input picks which one. For the same word it also produces a quieted copy and the default NaN pattern for the chosen format. A datapath uses it at the edge of an arithmetic unit. The unit can raise an invalid flag when it sees a signaling NaN, forward the quieted operand instead of the raw one, and put the default pattern in place of any NaN result.

Two static configuration inputs set how the fraction's top bit is read. The first picks which value of that bit marks a signaling NaN. The second turns on a mode in which signaling NaNs do not exist at all. A two-bit style input picks one of four default-NaN patterns. Operands sit right-aligned in a 64-bit input word, and bits above the selected format's width are ignored. The outputs pass through a register stage that a parameter can remove.

Top module: `fp_nan_quieter`

## Requirements
- R1: `fmt_sel` picks the format. 0 is half (1 sign, 5 exponent, 10 fraction bits). 1 is bfloat16 (1/8/7). 2 is single (1/8/23). 3 is double (1/11/52). The word occupies `din[W-1:0]`, where W is the format's total width.
- R2: With `snan_pol`=0 and `no_snan`=0, a word is signaling if its exponent is all ones, its fraction top bit is 0 and its lower fraction bits are nonzero. It is quiet if its exponent is all ones and its fraction top bit is 1.
- R3: With `snan_pol`=1 and `no_snan`=0, a word is signaling if its exponent is all ones and its fraction top bit is 1. It is quiet if its exponent is all ones, its fraction top bit is 0 and its lower fraction bits are nonzero.
- R4: Infinity (exponent all ones, fraction zero) and every word with an exponent that is not all ones set neither `is_qnan` nor `is_snan`.
- R5: With `no_snan`=1, `is_snan` is always 0, and every NaN (exponent all ones, fraction nonzero) sets `is_qnan`.
- R6: When `snan_pol`=0, quieting a signaling NaN sets the fraction top bit and leaves every other bit unchanged.
- R7: When `snan_pol`=1, quieting a signaling NaN clears the fraction top bit, sets the bit just below it, and leaves every other bit unchanged.
- R8: `quiet_out` equals the selected word for non-NaNs and quiet NaNs. Bits of `quiet_out` and `dflt_nan` above the format width are 0.
- R9: `dflt_nan` has an all-ones exponent. The sign and fraction depend on `dnan_style`. Style 0 has sign 0 and only the fraction top bit set when `snan_pol`=0, or every fraction bit except the top one set when `snan_pol`=1. Style 1 has sign 0 and all fraction bits set. Style 2 has sign 1 and only the top fraction bit set. Style 3 has sign 0 and only the bit below the top set.
- R10: With OUT_REG=1, every output reflects the inputs one clock edge later. A synchronous active-high `rst` drives all outputs to 0 at the next edge.
- R11: `is_qnan` and `is_snan` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Format select (0 half, 1 bfloat16, 2 single, 3 double) |
| snan_pol | input | 1 | Fraction top-bit value that marks a signaling NaN |
| no_snan | input | 1 | Treat all NaNs as quiet |
| dnan_style | input | 2 | Default-NaN pattern style |
| din | input | 64 | Operand, right-aligned |
| is_qnan | output | 1 | Operand is a quiet NaN |
| is_snan | output | 1 | Operand is a signaling NaN |
| quiet_out | output | 64 | Operand with any signaling NaN quieted |
| dflt_nan | output | 64 | Default NaN for the selected format and style |

## Verification
Assertions check three things on every cycle: the two class flags are never both set, the no-signaling mode never reports a signaling NaN, and any word not classed as signaling comes out of the quieting path unchanged apart from the masking of the upper bits. They also check that the output stage delays its input by one cycle and clears on reset. Only the bench's scenarios can show the exact bit the quieting path flips in each format and polarity. The same holds for the default pattern produced by each style, and for infinity and ordinary numbers staying unclassified.

// File: rtl/nanq_pkg.sv
package nanq_pkg;

  localparam int unsigned NUM_FMT = 4;
  localparam int unsigned WORD_W  = 64;
  localparam int unsigned FMT_W   = 2;
  localparam int unsigned STYLE_W = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_HALF   = 2'd0,
    FMT_BF16   = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_DOUBLE = 2'd3
  } fmt_e;

  typedef enum logic [STYLE_W-1:0] {
    DN_QBIT    = 2'd0,
    DN_ALLFRAC = 2'd1,
    DN_NEGTOP  = 2'd2,
    DN_SUBTOP  = 2'd3
  } dnan_style_e;

  function automatic int unsigned exp_bits(input int unsigned f);
    case (f)
      0:       return 5;
      1:       return 8;
      2:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int unsigned frac_bits(input int unsigned f);
    case (f)
      0:       return 10;
      1:       return 7;
      2:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic int unsigned word_bits(input int unsigned f);
    return 1 + exp_bits(f) + frac_bits(f);
  endfunction

endpackage

// File: rtl/nanq_lane.sv
module nanq_lane #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned LW    = 1 + EXP_W + FRAC_W
) (
  input  logic [LW-1:0] word,
  input  logic          snan_pol,
  input  logic          no_snan,
  input  logic [1:0]    style,
  output logic          q_nan,
  output logic          s_nan,
  output logic [LW-1:0] quieted,
  output logic [LW-1:0] dflt
);
  localparam logic [FRAC_W-1:0] TOP_BIT = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] SUB_BIT = TOP_BIT >> 1;

  logic exp_ones, frac_top, frac_low_nz, any_nan;

  assign exp_ones    = &word[LW-2:FRAC_W];
  assign frac_top    = word[FRAC_W-1];
  assign frac_low_nz = |word[FRAC_W-2:0];
  assign any_nan     = exp_ones & (frac_top | frac_low_nz);

  // classification
  always_comb begin
    if (no_snan) begin
      q_nan = any_nan;
      s_nan = 1'b0;
    end else if (snan_pol) begin
      s_nan = exp_ones & frac_top;
      q_nan = exp_ones & ~frac_top & frac_low_nz;
    end else begin
      s_nan = exp_ones & ~frac_top & frac_low_nz;
      q_nan = exp_ones & frac_top;
    end
  end

  // quieting: only a signaling NaN is modified
  always_comb begin
    quieted = word;
    if (s_nan) begin
      if (snan_pol) begin
        quieted[FRAC_W-1] = 1'b0;
        quieted[FRAC_W-2] = 1'b1;
      end else begin
        quieted[FRAC_W-1] = 1'b1;
      end
    end
  end

  // default NaN pattern
  logic              dn_sign;
  logic [FRAC_W-1:0] dn_frac;

  always_comb begin
    dn_sign = 1'b0;
    case (style)
      2'd0:    dn_frac = snan_pol ? ~TOP_BIT : TOP_BIT;
      2'd1:    dn_frac = '1;
      2'd2: begin
        dn_sign = 1'b1;
        dn_frac = TOP_BIT;
      end
      default: dn_frac = SUB_BIT;
    endcase
    dflt = {dn_sign, {EXP_W{1'b1}}, dn_frac};
  end

endmodule

// File: rtl/nanq_out_stage.sv
module nanq_out_stage #(
  parameter int unsigned W  = 8,
  parameter bit          EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d;
      end
      assign q = r;

      // R10
      stage_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> q == $past(d));
      // R10
      stage_reset_chk: assert property (@(posedge clk)
        rst |=> q == '0);
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/fp_nan_quieter.sv
module fp_nan_quieter #(
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  fmt_sel,
  input  logic        snan_pol,
  input  logic        no_snan,
  input  logic [1:0]  dnan_style,
  input  logic [63:0] din,
  output logic        is_qnan,
  output logic        is_snan,
  output logic [63:0] quiet_out,
  output logic [63:0] dflt_nan
);
  import nanq_pkg::*;

  localparam int unsigned PACK_W = 2 + 2 * WORD_W;

  logic              lane_q     [NUM_FMT];
  logic              lane_s     [NUM_FMT];
  logic [WORD_W-1:0] lane_quiet [NUM_FMT];
  logic [WORD_W-1:0] lane_dflt  [NUM_FMT];
  logic [WORD_W-1:0] lane_mask  [NUM_FMT];

  generate
    for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
      localparam int unsigned EW = exp_bits(g);
      localparam int unsigned FW = frac_bits(g);
      localparam int unsigned LW = 1 + EW + FW;
      logic [LW-1:0] lq, ld;
      nanq_lane #(.EXP_W(EW), .FRAC_W(FW)) u_lane (
        .word     (din[LW-1:0]),
        .snan_pol (snan_pol),
        .no_snan  (no_snan),
        .style    (dnan_style),
        .q_nan    (lane_q[g]),
        .s_nan    (lane_s[g]),
        .quieted  (lq),
        .dflt     (ld)
      );
      assign lane_quiet[g] = WORD_W'(lq);
      assign lane_dflt[g]  = WORD_W'(ld);
      assign lane_mask[g]  = WORD_W'({LW{1'b1}});
    end
  endgenerate

  logic              sel_q, sel_s;
  logic [WORD_W-1:0] sel_quiet, sel_dflt, sel_mask;

  always_comb begin
    sel_q     = lane_q[fmt_sel];
    sel_s     = lane_s[fmt_sel];
    sel_quiet = lane_quiet[fmt_sel];
    sel_dflt  = lane_dflt[fmt_sel];
    sel_mask  = lane_mask[fmt_sel];
  end

  logic [PACK_W-1:0] pk_in, pk_out;
  assign pk_in = {sel_q, sel_s, sel_quiet, sel_dflt};

  nanq_out_stage #(.W(PACK_W), .EN(OUT_REG)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (pk_in),
    .q   (pk_out)
  );

  assign {is_qnan, is_snan, quiet_out, dflt_nan} = pk_out;

  // R11
  class_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel_q && sel_s));
  // R5
  no_snan_mode_chk: assert property (@(posedge clk) disable iff (rst)
    no_snan |-> !sel_s);
  // R8
  passthru_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_s |-> sel_quiet == (din & sel_mask));
  // R8
  dflt_width_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_dflt & ~sel_mask) == '0);

endmodule

// File: tb/sim_fp_nan_quieter.sv
`timescale 1ns/1ps
module sim_fp_nan_quieter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt_sel = 2'd0;
  logic        snan_pol = 1'b0;
  logic        no_snan = 1'b0;
  logic [1:0]  dnan_style = 2'd0;
  logic [63:0] din = '0;
  logic        is_qnan, is_snan;
  logic [63:0] quiet_out, dflt_nan;

  always #2.5 clk = ~clk;

  fp_nan_quieter u0 (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .snan_pol(snan_pol),
    .no_snan(no_snan), .dnan_style(dnan_style), .din(din),
    .is_qnan(is_qnan), .is_snan(is_snan), .quiet_out(quiet_out),
    .dflt_nan(dflt_nan)
  );

  typedef struct packed {
    logic [1:0]  fmt;
    logic        pol;
    logic        nos;
    logic [1:0]  sty;
    logic [63:0] din;
    logic        eq;
    logic        es;
    logic [63:0] equiet;
    logic [63:0] edflt;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{2'd2,1'b0,1'b0,2'd0,64'h7F800001, 1'b0,1'b1,64'h7FC00001,64'h7FC00000},
    '{2'd2,1'b0,1'b0,2'd0,64'h7FC00000, 1'b1,1'b0,64'h7FC00000,64'h7FC00000},
    '{2'd2,1'b0,1'b0,2'd1,64'h7F800000, 1'b0,1'b0,64'h7F800000,64'h7FFFFFFF},
    '{2'd2,1'b1,1'b0,2'd0,64'h7FC00000, 1'b0,1'b1,64'h7FA00000,64'h7FBFFFFF},
    '{2'd2,1'b1,1'b0,2'd3,64'h7F800001, 1'b1,1'b0,64'h7F800001,64'h7FA00000},
    '{2'd0,1'b0,1'b0,2'd0,64'hFC01,     1'b0,1'b1,64'hFE01,    64'h7E00},
    '{2'd0,1'b1,1'b0,2'd2,64'h7E00,     1'b0,1'b1,64'h7D00,    64'hFE00},
    '{2'd1,1'b0,1'b0,2'd0,64'h7F81,     1'b0,1'b1,64'h7FC1,    64'h7FC0},
    '{2'd1,1'b0,1'b0,2'd3,64'h3F80,     1'b0,1'b0,64'h3F80,    64'h7FA0},
    '{2'd3,1'b0,1'b0,2'd0,64'h7FF0000000000001, 1'b0,1'b1,64'h7FF8000000000001,64'h7FF8000000000000},
    '{2'd3,1'b1,1'b0,2'd1,64'hFFF8000000000000, 1'b0,1'b1,64'hFFF4000000000000,64'h7FFFFFFFFFFFFFFF},
    '{2'd2,1'b0,1'b1,2'd0,64'h7F800001, 1'b1,1'b0,64'h7F800001,64'h7FC00000},
    '{2'd2,1'b1,1'b1,2'd2,64'h7FC00000, 1'b1,1'b0,64'h7FC00000,64'hFFC00000},
    '{2'd0,1'b0,1'b0,2'd0,64'hDEAD000012347C00, 1'b0,1'b0,64'h7C00,64'h7E00},
    '{2'd3,1'b0,1'b0,2'd2,64'h7FF0000000000000, 1'b0,1'b0,64'h7FF0000000000000,64'hFFF8000000000000},
    '{2'd1,1'b1,1'b0,2'd0,64'h7FA0,     1'b1,1'b0,64'h7FA0,    64'h7FBF}
  };
  // Requirement tags per vector: 0 R2 R6, 1 R2, 2 R4 R9, 3 R3 R7 R9, 4 R3 R9,
  // 5 R1 R6, 6 R1 R7 R9, 7 R1 R6, 8 R4 R9, 9 R1 R6, 10 R7 R9, 11 R5,
  // 12 R5 R9, 13 R8, 14 R4 R9, 15 R3 R8

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    fmt_sel = v.fmt; snan_pol = v.pol; no_snan = v.nos;
    dnan_style = v.sty; din = v.din;
  endtask

  task automatic check_vec(input vec_t v, input int idx);
    string tag;
    tag = $sformatf("vector %0d R1-class", idx);
    chk({tag, " q (R2/R3/R5)"}, 64'(is_qnan), 64'(v.eq));
    chk({tag, " s (R2/R3/R4)"}, 64'(is_snan), 64'(v.es));
    chk({tag, " quiet (R6/R7/R8)"}, quiet_out, v.equiet);
    chk({tag, " dflt (R9)"}, dflt_nan, v.edflt);
    chk({tag, " excl R11"}, 64'(is_qnan & is_snan), 64'd0);
  endtask

  initial begin
    // reset state, R10: a signaling NaN is driven while reset is held
    drive(TBL[0]);
    repeat (3) @(negedge clk);
    chk("R10 reset q", 64'(is_qnan), 64'd0);
    chk("R10 reset s", 64'(is_snan), 64'd0);
    chk("R10 reset quiet", quiet_out, 64'd0);
    chk("R10 reset dflt", dflt_nan, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      @(negedge clk);
      check_vec(TBL[i], i);
    end

    // R10 latency: new input must not appear before the next edge
    @(negedge clk);
    drive(TBL[9]);
    @(negedge clk);
    drive(TBL[6]);
    #1;
    chk("R10 latency hold quiet", quiet_out, TBL[9].equiet);
    @(negedge clk);
    chk("R10 latency update quiet", quiet_out, TBL[6].equiet);

    // R10 mid-run synchronous reset
    rst = 1'b1;
    @(negedge clk);
    chk("R10 midrun reset s", 64'(is_snan), 64'd0);
    chk("R10 midrun reset quiet", quiet_out, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 after reset s", 64'(is_snan), 64'd1);

    // R4 finite double with all-ones fraction is not a NaN
    fmt_sel = 2'd3; snan_pol = 1'b0; no_snan = 1'b0; din = 64'h7FEFFFFFFFFFFFFF;
    @(negedge clk);
    chk("R4 finite q", 64'(is_qnan), 64'd0);
    chk("R4 finite s", 64'(is_snan), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule